// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block sits behind three bus comparators in an on-chip debug unit. Each cycle it receives one match pulse per comparator channel (channel 0, 1 and 2). It walks through three intermediate states toward a final state. On reaching the final state it raises a one-cycle break request to the processor. The current intermediate state selects one of three 4-bit control words, and that word decides where each channel's match sends the sequencer.

When several channels match in the same cycle, a match that leads to the final state always wins. Only if no such match is present does the lowest-numbered channel win. Because of this rule a programmed path can fall back to an earlier state on one channel while another channel completes the sequence. That makes "the same event twice with no other event between" detectable with just two comparators. When channel 0 compares against an address range, channel 1 is consumed by that comparison and its match line is ignored.

The arm input is a level. While it is low the sequencer rests in the first state and ignores matches. While it is high the sequencer steps on each rising clock edge. After the final state is reached it stays there until arm is dropped.

Top module: `dbg_trig_seq`

## Requirements
- R1: While reset is asserted and after it is released, state_o reads 2'b01 (first state), done_o is 0 and trig_o is 0.
- R2: While arm_i is low, the next edge puts the sequencer in the first state (state_o 2'b01, done_o 0), and match pulses have no effect.
- R3: Control bits [3:2] name the completing channel: 00 none, 01 channel 0, 10 channel 1, 11 channel 2. A match on the completing channel moves the sequencer to the final state.
- R4: The partner channel is channel 2 when bits [3:2] are 01 or 10, and channel 0 when they are 11 or 00. Bits [1:0] send a partner match to the first (01), second (10) or third (11) state. The value 00 gives the partner match no effect.
- R5: When bits [3:2] are 00, a channel 2 match sends the sequencer to the first state. When bits [3:2] are 01 or 10, no encoding sends the remaining third channel anywhere.
- R6: When several channels with an effect match in one cycle and one of them leads to the final state, the sequencer enters the final state.
- R7: When several channels with an effect match in one cycle and none leads to the final state, the lowest-numbered of them decides the next state.
- R8: While range_i is high, the channel 1 match line is ignored.
- R9: Entering the final state sets done_o and drives state_o to 2'b00. trig_o is high for exactly the one cycle after the entering edge.
- R10: Once in the final state, the sequencer stays there while arm_i stays high, whatever the matches. Dropping arm_i returns it to the first state.
- R11: state_o reads 2'b01, 2'b10 or 2'b11 for the first, second or third state. In each of these states the control word of that same state (ctl_s1_i, ctl_s2_i, ctl_s3_i) governs the transitions.
- R12: A path that uses a fallback transition detects two consecutive events on one channel with no event on the other between them. This works for either channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| arm_i | input | 1 | Level arm; low holds the sequencer in the first state |
| range_i | input | 1 | Channel 0 in range mode; masks channel 1 |
| match_i | input | 3 | Per-channel comparator match pulses, bit n for channel n |
| ctl_s1_i | input | 4 | Control word used in the first state |
| ctl_s2_i | input | 4 | Control word used in the second state |
| ctl_s3_i | input | 4 | Control word used in the third state |
| state_o | output | 2 | Current state code (01, 10, 11; 00 when final) |
| done_o | output | 1 | Sequencer is in the final state |
| trig_o | output | 1 | One-cycle break request on entry to the final state |

## Verification
All three results come from registers. The arm, range, match and control values present at one rising edge show up on state_o, done_o and trig_o straight after that edge, with no further latency. The trigger pulse is gone by the edge after that. The driver sets inputs on the falling edge and queues the expected triple for the coming rising edge. The monitor pops one entry per rising edge and compares it 2 ns after that edge, so each check lands in the single cycle that its stimulus governs.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

  localparam int unsigned CH_N     = 3;
  localparam int unsigned CTL_W    = 4;
  localparam int unsigned ST_W     = 2;
  localparam int unsigned RANGE_CH = 1;

  typedef enum logic [ST_W-1:0] {
    ST_FIN = 2'b00,
    ST_ONE = 2'b01,
    ST_TWO = 2'b10,
    ST_THR = 2'b11
  } seq_st_e;

  typedef struct packed {
    logic    en;
    seq_st_e st;
  } hop_t;

endpackage

// File: rtl/dbg_trig_rst_sync.sv
module dbg_trig_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else begin
      sr_q <= {sr_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sr_q[STAGES-1];

endmodule

// File: rtl/dbg_trig_route.sv
module dbg_trig_route
  import dbg_trig_pkg::*;
#(
  parameter int unsigned CHN = CH_N
) (
  input  logic [CTL_W-1:0] ctl_i,
  output hop_t [CHN-1:0]   hop_o
);

  localparam int unsigned LAST = CHN - 1;

  logic [1:0] fin_sel;
  logic [1:0] redir;
  logic [1:0] partner;

  assign fin_sel = ctl_i[3:2];
  assign redir   = ctl_i[1:0];
  // completing channel 0 or 1 pairs with channel 2; otherwise channel 0 is the partner
  assign partner = (fin_sel == 2'd1 || fin_sel == 2'd2) ? 2'(LAST) : 2'd0;

  for (genvar g = 0; g < CHN; g++) begin : g_ch
    hop_t hop_g;

    always_comb begin
      hop_g = '{en: 1'b0, st: ST_ONE};
      if (fin_sel != 2'd0 && int'(fin_sel) == g + 1) begin
        hop_g = '{en: 1'b1, st: ST_FIN};
      end else if (int'(partner) == g && redir != 2'd0) begin
        hop_g = '{en: 1'b1, st: seq_st_e'(redir)};
      end else if (fin_sel == 2'd0 && g == LAST) begin
        hop_g = '{en: 1'b1, st: ST_ONE};
      end
    end

    assign hop_o[g] = hop_g;
  end

endmodule

// File: rtl/dbg_trig_arb.sv
module dbg_trig_arb
  import dbg_trig_pkg::*;
#(
  parameter int unsigned CHN = CH_N
) (
  input  logic [CHN-1:0] hit_i,
  input  hop_t [CHN-1:0] hop_i,
  output logic           go_o,
  output seq_st_e        dst_o
);

  logic fin_hit;

  always_comb begin
    go_o    = 1'b0;
    dst_o   = ST_ONE;
    fin_hit = 1'b0;
    // scan downward so the lowest active channel is written last
    for (int i = CHN - 1; i >= 0; i--) begin
      if (hit_i[i] && hop_i[i].en) begin
        go_o  = 1'b1;
        dst_o = hop_i[i].st;
      end
    end
    for (int i = 0; i < CHN; i++) begin
      if (hit_i[i] && hop_i[i].en && hop_i[i].st == ST_FIN) begin
        fin_hit = 1'b1;
      end
    end
    if (fin_hit) begin
      dst_o = ST_FIN;
    end
  end

endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq
  import dbg_trig_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic             range_i,
  input  logic [CH_N-1:0]  match_i,
  input  logic [CTL_W-1:0] ctl_s1_i,
  input  logic [CTL_W-1:0] ctl_s2_i,
  input  logic [CTL_W-1:0] ctl_s3_i,
  output logic [ST_W-1:0]  state_o,
  output logic             done_o,
  output logic             trig_o
);

  logic             rst_sn;
  seq_st_e          st_q;
  seq_st_e          st_d;
  logic             st_en;
  logic             trig_q;
  logic             trig_d;
  logic [CTL_W-1:0] ctl_cur;
  logic [CH_N-1:0]  ch_mask;
  logic [CH_N-1:0]  hit;
  hop_t [CH_N-1:0]  hop;
  logic             go;
  seq_st_e          dst;

  dbg_trig_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sn)
  );

  always_comb begin
    unique case (st_q)
      ST_ONE:  ctl_cur = ctl_s1_i;
      ST_TWO:  ctl_cur = ctl_s2_i;
      ST_THR:  ctl_cur = ctl_s3_i;
      default: ctl_cur = '0;
    endcase
  end

  for (genvar c = 0; c < CH_N; c++) begin : g_mask
    if (c == RANGE_CH) begin : g_rng
      assign ch_mask[c] = ~range_i;
    end else begin : g_pass
      assign ch_mask[c] = 1'b1;
    end
  end

  assign hit = match_i & ch_mask & {CH_N{arm_i}};

  dbg_trig_route #(.CHN(CH_N)) u_route (
    .ctl_i (ctl_cur),
    .hop_o (hop)
  );

  dbg_trig_arb #(.CHN(CH_N)) u_arb (
    .hit_i (hit),
    .hop_i (hop),
    .go_o  (go),
    .dst_o (dst)
  );

  // next-state decode
  always_comb begin
    st_en  = !arm_i || (go && st_q != ST_FIN);
    st_d   = arm_i ? dst : ST_ONE;
    trig_d = arm_i && go && st_q != ST_FIN && dst == ST_FIN;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q   <= ST_ONE;
      trig_q <= 1'b0;
    end else begin
      if (st_en) begin
        st_q <= st_d;
      end
      trig_q <= trig_d;
    end
  end

  assign state_o = st_q;
  assign done_o  = (st_q == ST_FIN);
  assign trig_o  = trig_q;

  assert_disarm_home_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    !arm_i |=> (state_o == 2'b01 && !done_o && !trig_o));

  assert_fin_wins_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    (arm_i && st_q == ST_THR && ctl_s3_i == 4'b1110 && match_i[0] && match_i[2]) |=> done_o);

  assert_range_mask_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    (arm_i && range_i && match_i == 3'b010) |=> $stable(state_o));

  assert_trig_single_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    trig_o |=> !trig_o);

  assert_trig_entry_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    trig_o |-> (done_o && !$past(done_o)));

  assert_fin_hold_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    (done_o && arm_i) |=> done_o);

endmodule

// File: tb/test_dbg_trig_seq.sv
module test_dbg_trig_seq;

  logic       clk;
  logic       rst_n;
  logic       arm;
  logic       rng;
  logic [2:0] match;
  logic [3:0] c1;
  logic [3:0] c2;
  logic [3:0] c3;
  logic [1:0] state_o;
  logic       done_o;
  logic       trig_o;

  logic       rng_v;
  logic [3:0] c1_v;
  logic [3:0] c2_v;
  logic [3:0] c3_v;

  int n_run;
  int n_fail;

  logic [1:0] q_st[$];
  logic       q_dn[$];
  logic       q_tr[$];
  string      q_req[$];

  dbg_trig_seq i_dbg_trig_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_i    (arm),
    .range_i  (rng),
    .match_i  (match),
    .ctl_s1_i (c1),
    .ctl_s2_i (c2),
    .ctl_s3_i (c3),
    .state_o  (state_o),
    .done_o   (done_o),
    .trig_o   (trig_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string r, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got state/done/trig %b, expected %b", r, act, exp);
    end
  endtask

  task automatic setc(input logic [3:0] a, input logic [3:0] b, input logic [3:0] c);
    c1_v = a;
    c2_v = b;
    c3_v = c;
  endtask

  // driver: inputs on the falling edge, expectation for the next rising edge
  task automatic step(input logic a, input logic [2:0] m, input logic [1:0] es,
                      input logic ed, input logic et, input string r);
    @(negedge clk);
    arm   = a;
    match = m;
    rng   = rng_v;
    c1    = c1_v;
    c2    = c2_v;
    c3    = c3_v;
    q_st.push_back(es);
    q_dn.push_back(ed);
    q_tr.push_back(et);
    q_req.push_back(r);
  endtask

  // monitor: one expectation consumed per rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_st.size() > 0) begin
        logic [1:0] es;
        logic       ed;
        logic       et;
        string      r;
        es = q_st.pop_front();
        ed = q_dn.pop_front();
        et = q_tr.pop_front();
        r  = q_req.pop_front();
        chk(r, {state_o, done_o, trig_o}, {es, ed, et});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got running, expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run  = 0;
    n_fail = 0;
    rst_n  = 1'b0;
    arm    = 1'b0;
    rng    = 1'b0;
    match  = 3'b000;
    c1 = '0; c2 = '0; c3 = '0;
    rng_v = 1'b0;
    setc(4'b0000, 4'b0000, 4'b0000);

    repeat (3) @(posedge clk);
    #2;
    chk("R1 in reset", {state_o, done_o, trig_o}, {2'b01, 1'b0, 1'b0});
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release", {state_o, done_o, trig_o}, {2'b01, 1'b0, 1'b0});

    // channel 0 completes from the first state
    setc(4'b0100, 4'b0000, 4'b0000);
    step(1, 3'b000, 2'd1, 0, 0, "R11 idle armed");
    step(1, 3'b001, 2'd0, 1, 1, "R3 ch0 completes");
    step(1, 3'b000, 2'd0, 1, 0, "R9 pulse ends");
    step(1, 3'b111, 2'd0, 1, 0, "R10 hold final");
    step(0, 3'b000, 2'd1, 0, 0, "R10 disarm returns");

    // disarmed matches ignored
    step(0, 3'b001, 2'd1, 0, 0, "R2 ignored ch0");
    step(0, 3'b101, 2'd1, 0, 0, "R2 ignored ch0+ch2");

    // partner routing and per-state control words
    setc(4'b0010, 4'b1111, 4'b1001);
    step(1, 3'b000, 2'd1, 0, 0, "R11 first state");
    step(1, 3'b100, 2'd1, 0, 0, "R5 ch2 to first");
    step(1, 3'b001, 2'd2, 0, 0, "R4 ch0 to second");
    step(1, 3'b010, 2'd2, 0, 0, "R3 ch1 no effect");
    step(1, 3'b001, 2'd3, 0, 0, "R4 ch0 to third");
    step(1, 3'b100, 2'd1, 0, 0, "R4 ch2 partner to first");
    step(1, 3'b001, 2'd2, 0, 0, "R11 second again");
    step(1, 3'b001, 2'd3, 0, 0, "R11 third again");
    step(1, 3'b001, 2'd3, 0, 0, "R5 ch0 no effect");
    step(1, 3'b010, 2'd0, 1, 1, "R3 ch1 completes");
    step(0, 3'b000, 2'd1, 0, 0, "R2 disarm");

    // final-state priority with a fallback path
    setc(4'b0010, 4'b0011, 4'b1110);
    step(1, 3'b001, 2'd2, 0, 0, "R4 to second");
    step(1, 3'b001, 2'd3, 0, 0, "R4 to third");
    step(1, 3'b001, 2'd2, 0, 0, "R4 fall back");
    step(1, 3'b001, 2'd3, 0, 0, "R4 to third again");
    step(1, 3'b101, 2'd0, 1, 1, "R6 final wins");
    step(0, 3'b000, 2'd1, 0, 0, "R2 disarm");

    // lowest channel wins otherwise
    setc(4'b0011, 4'b0000, 4'b0011);
    step(1, 3'b101, 2'd3, 0, 0, "R7 ch0 over ch2");
    step(1, 3'b101, 2'd3, 0, 0, "R7 ch0 stays");
    step(1, 3'b100, 2'd1, 0, 0, "R5 ch2 alone");
    step(0, 3'b000, 2'd1, 0, 0, "R2 disarm");

    // range mode masks channel 1
    rng_v = 1'b1;
    setc(4'b1000, 4'b0000, 4'b0000);
    step(1, 3'b010, 2'd1, 0, 0, "R8 ch1 masked");
    step(1, 3'b111, 2'd1, 0, 0, "R8 all masked");
    rng_v = 1'b0;
    step(1, 3'b010, 2'd0, 1, 1, "R8 ch1 live again");
    step(0, 3'b000, 2'd1, 0, 0, "R2 disarm");

    // two channel-0 events with no channel-2 event between
    setc(4'b0010, 4'b0101, 4'b0000);
    step(1, 3'b001, 2'd2, 0, 0, "R12 A first");
    step(1, 3'b100, 2'd1, 0, 0, "R12 B resets");
    step(1, 3'b001, 2'd2, 0, 0, "R12 A again");
    step(1, 3'b001, 2'd0, 1, 1, "R12 A twice");
    step(0, 3'b000, 2'd1, 0, 0, "R2 disarm");

    // two channel-2 events with no channel-0 event between
    setc(4'b1010, 4'b1101, 4'b0000);
    step(1, 3'b100, 2'd2, 0, 0, "R12 B first");
    step(1, 3'b001, 2'd1, 0, 0, "R12 A resets");
    step(1, 3'b100, 2'd2, 0, 0, "R12 B again");
    step(1, 3'b100, 2'd0, 1, 1, "R12 B twice");
    step(0, 3'b000, 2'd1, 0, 0, "R2 disarm");

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule